// File: doc/BRIEF.md
# Configurable SPI Frame Transmitter

This block drives a write-only three-line serial link (active-low chip select, serial clock, serial data) to load a serial DAC. A start strobe captures a data word of up to 64 bits together with a bit count, an alignment flag and a bit-order flag. The block then shifts exactly that many bits out, one bit per clock period, at a rate set by a parameter. Busy is high for the whole frame, and done pulses once when the frame closes.

A dual-channel mode serves a two-output DAC. When it is selected, two 12-bit channel values are joined into one 24-bit word, with channel A in bits 23:12 and channel B in bits 11:0. That word is sent most significant bit first and right aligned. In this mode the generic word, the count and the flags are not used.

The 64-bit word may hold its payload at the low end (right aligned) or at the high end (left aligned). Either bit order may be used with either alignment.

Top module: `spi_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, cs_n_o is 1 and sclk_o, sdo_o, busy_o and done_o are 0.
- R2: A start_i sampled high while idle brings cs_n_o to 0 and busy_o to 1 in the next cycle. A lead step of CLK_DIV cycles follows, with sclk_o and sdo_o at 0. The first rising edge of sclk_o therefore comes 2*CLK_DIV cycles after cs_n_o falls.
- R3: For each bit, sdo_o carries the bit for CLK_DIV cycles while sclk_o is 0. sclk_o is then 1 for CLK_DIV cycles, and sdo_o does not change across the rising edge or during the high phase.
- R4: The number of rising edges of sclk_o in a frame equals width_i, for width_i from 1 to 64.
- R5: With msb_i=1 and left_i=0, the bits are sent in the order data_i[width-1], data_i[width-2], and so on down to data_i[0].
- R6: With msb_i=1 and left_i=1, the bits are sent in the order data_i[63], data_i[62], and so on down to data_i[64-width].
- R7: With msb_i=0 and left_i=0, the bits are sent in the order data_i[0], data_i[1], and so on up to data_i[width-1].
- R8: With msb_i=0 and left_i=1, the bits are sent in the order data_i[64-width] and upward through data_i[63].
- R9: After the last high phase there is a trail step of CLK_DIV cycles with cs_n_o at 0 and sclk_o and sdo_o at 0. cs_n_o then returns to 1, and in that same cycle busy_o falls and done_o is 1 for exactly one cycle. A frame keeps cs_n_o low for CLK_DIV*(2*width+2) cycles.
- R10: With dual_i=1, the frame is 24 bits long and sends {ch_a_i, ch_b_i} MSB first, right aligned. data_i, width_i, left_i and msb_i are ignored.
- R11: A start_i pulse during a frame has no effect: the frame is unchanged and no second frame follows it. Changes to data_i, width_i, the flags, dual_i and the channel inputs after the start cycle do not alter the frame in progress.
- R12: Each lead, low, high and trail step lasts CLK_DIV system clock cycles, where CLK_DIV is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken only when idle |
| data_i | input | 64 | Word to send |
| width_i | input | 7 | Bit count, 1 to 64 |
| left_i | input | 1 | 1: payload sits at the top of the word |
| msb_i | input | 1 | 1: most significant payload bit goes first |
| dual_i | input | 1 | 1: send the two 12-bit channel values as one 24-bit frame |
| ch_a_i | input | 12 | Channel A value, sent in bits 23:12 |
| ch_b_i | input | 12 | Channel B value, sent in bits 11:0 |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock; the device samples on the rising edge |
| sdo_o | output | 1 | Serial data |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when chip select is released |

## Verification
The assertions check the line-level rules on every cycle. They cover quiet lines while chip select is released, a quiet lead step, data held steady across and during each high phase, the high-phase length, and a single done pulse that coincides with chip select rising. Bit order, alignment, bit count, the dual-channel packing and the indifference to late input changes and repeated start pulses can only be shown by the bench's frames. The bench compares each captured frame bit by bit against a word it computes itself from the requirements.

// File: rtl/spi_frame_tx.sv
module spi_frame_tx #(
  parameter int DW      = 64,
  parameter int CHW     = 12,
  parameter int CLK_DIV = 2,
  localparam int WW     = $clog2(DW) + 1,
  localparam int CW     = $clog2(CLK_DIV + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [DW-1:0]  data_i,
  input  logic [WW-1:0]  width_i,
  input  logic           left_i,
  input  logic           msb_i,
  input  logic           dual_i,
  input  logic [CHW-1:0] ch_a_i,
  input  logic [CHW-1:0] ch_b_i,
  output logic           cs_n_o,
  output logic           sclk_o,
  output logic           sdo_o,
  output logic           busy_o,
  output logic           done_o
);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TRAIL} st_t;

  st_t           st;
  logic [DW-1:0] sh;
  logic          msb_q;
  logic [WW-1:0] left_cnt;
  logic [CW-1:0] tick;
  logic          done_q;

  logic [WW-1:0] w_user, w_eff, gap;
  logic          msb_eff, left_eff;
  logic [DW-1:0] ld_word, ld_sh;
  logic          step_end;

  assign w_user   = (width_i == '0) ? WW'(1) : ((width_i > WW'(DW)) ? WW'(DW) : width_i);
  assign w_eff    = dual_i ? WW'(2 * CHW) : w_user;
  assign msb_eff  = dual_i | msb_i;
  assign left_eff = ~dual_i & left_i;
  assign gap      = WW'(DW) - w_eff;
  assign ld_word  = dual_i ? {{(DW - 2 * CHW){1'b0}}, ch_a_i, ch_b_i} : data_i;
  assign step_end = (tick == CW'(CLK_DIV - 1));

  always_comb begin
    if (msb_eff && !left_eff)      ld_sh = ld_word << gap;
    else if (!msb_eff && left_eff) ld_sh = ld_word >> gap;
    else                           ld_sh = ld_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      msb_q    <= 1'b1;
      left_cnt <= '0;
      tick     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        tick <= '0;
        if (start_i) begin
          st       <= S_LEAD;
          sh       <= ld_sh;
          msb_q    <= msb_eff;
          left_cnt <= w_eff;
        end
      end else begin
        tick <= step_end ? '0 : tick + CW'(1);
        if (step_end) begin
          unique case (st)
            S_LEAD:  st <= S_LOW;
            S_LOW:   st <= S_HIGH;
            S_HIGH: begin
              sh       <= msb_q ? (sh << 1) : (sh >> 1);
              left_cnt <= left_cnt - WW'(1);
              st       <= (left_cnt == WW'(1)) ? S_TRAIL : S_LOW;
            end
            S_TRAIL: begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign cs_n_o = (st == S_IDLE);
  assign busy_o = (st != S_IDLE);
  assign sclk_o = (st == S_HIGH);
  assign sdo_o  = ((st == S_LOW) || (st == S_HIGH)) && (msb_q ? sh[DW-1] : sh[0]);
  assign done_o = done_q;

endmodule

// File: rtl/spi_frame_tx_chk.sv
module spi_frame_tx_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic busy_o,
  input logic done_o
);

  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 0;
    else        hi_cnt <= sclk_o ? hi_cnt + 1 : 0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (!sclk_o && !sdo_o));                               // R1

  AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (!sclk_o && !sdo_o && busy_o));              // R2

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> (!cs_n_o && busy_o));                               // R3

  AST_SDO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdo_o));                                    // R3

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_cnt == CLK_DIV));                        // R12

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                           // R9

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !busy_o && $past(!cs_n_o)));             // R9

endmodule

bind spi_frame_tx spi_frame_tx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_spi_frame_tx.sv
`timescale 1ns/1ps
module sim_spi_frame_tx;
  localparam int DIV = 3;

  logic        clk = 0, rst_n = 0, start_i = 0;
  logic [63:0] data_i = '0;
  logic [6:0]  width_i = 7'd8;
  logic        left_i = 0, msb_i = 1, dual_i = 0;
  logic [11:0] ch_a_i = '0, ch_b_i = '0;
  logic        cs_n_o, sclk_o, sdo_o, busy_o, done_o;

  spi_frame_tx #(.CLK_DIV(DIV)) u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // per-frame observations, taken at the falling edge
  int lowcnt = 0, nbits = 0, lead = -1, hibad = 0, hirun = 0, donecnt = 0, donebad = 0;
  logic [63:0] cap = '0;
  logic pcs = 1, psclk = 0, psdo = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n_o && pcs) begin
        lowcnt = 0; nbits = 0; lead = -1; hibad = 0; hirun = 0; cap = '0;
      end
      if (!cs_n_o) lowcnt++;
      if (sclk_o && cs_n_o) hibad++;
      if (sclk_o && !psclk) begin
        if (sdo_o != psdo) hibad++;
        if (nbits < 64) cap[nbits] = sdo_o;
        nbits++;
        if (lead < 0) lead = lowcnt - 1;
        hirun = 0;
      end
      if (sclk_o) begin
        hirun++;
        if (psclk && sdo_o != psdo) hibad++;
      end
      if (!sclk_o && psclk && hirun != DIV) hibad++;
      if (done_o) begin
        donecnt++;
        if (!(cs_n_o && !pcs)) donebad++;
      end
    end
    pcs = cs_n_o; psclk = sclk_o; psdo = sdo_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expv(logic [63:0] d, int w, bit left, bit msb);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int idx;
      idx = msb ? (left ? 63 - i : w - 1 - i) : (left ? 64 - w + i : i);
      r[i] = d[idx];
    end
    return r;
  endfunction

  task automatic frame(logic [63:0] d, int w, bit left, bit msb, bit dual,
                       logic [11:0] a, logic [11:0] b, bit poke);
    int ew, k, stray;
    logic [63:0] ev;
    string tag;
    if (dual) begin
      ew = 24; ev = expv({40'b0, a, b}, 24, 0, 1); tag = "R10";
    end else begin
      ew = w; ev = expv(d, w, left, msb);
      tag = msb ? (left ? "R6" : "R5") : (left ? "R8" : "R7");
    end
    @(negedge clk);
    data_i = d; width_i = 7'(w); left_i = left; msb_i = msb; dual_i = dual;
    ch_a_i = a; ch_b_i = b; start_i = 1; donecnt = 0; donebad = 0;
    @(negedge clk);
    start_i = 0;
    check(busy_o && !cs_n_o, "R2 busy/cs after start", {busy_o, cs_n_o}, 2'b10);
    data_i = {$urandom, $urandom}; width_i = 7'($urandom_range(1, 64));
    left_i = 1'($urandom); msb_i = 1'($urandom); dual_i = 1'($urandom);
    ch_a_i = 12'($urandom); ch_b_i = 12'($urandom);
    k = 0;
    while (!done_o && k < 2000) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) start_i = 1;
      if (k == 3) start_i = 0;
    end
    check(!busy_o, "R9 busy low at done", busy_o, 0);
    stray = 0;
    repeat (4) begin
      @(negedge clk);
      if (!cs_n_o || busy_o) stray++;
    end
    check(stray == 0, poke ? "R11 no frame after stray start" : "R1 idle after frame", stray, 0);
    check(nbits == ew, "R4 bit count", nbits, ew);
    check(cap == ev, {tag, " bit order / R11 latched inputs"}, cap, ev);
    check(lead == 2 * DIV, "R2 lead length", lead, 2 * DIV);
    check(lowcnt == DIV * (2 * ew + 2), "R12 frame length", lowcnt, DIV * (2 * ew + 2));
    check(hibad == 0, "R3 data held over high phase", hibad, 0);
    check(donecnt == 1 && donebad == 0, "R9 single done at release", donecnt, 1);
  endtask

  initial begin
    void'($urandom(32'h5A17C3));
    #1;
    check(cs_n_o && !sclk_o && !sdo_o && !busy_o && !done_o, "R1 reset state",
          {cs_n_o, sclk_o, sdo_o, busy_o, done_o}, 5'b10000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cs_n_o && !busy_o, "R1 idle after reset", {cs_n_o, busy_o}, 2'b10);

    frame(64'h8000_0000_0000_0001, 1,  0, 1, 0, 0, 0, 0);
    frame(64'h8000_0000_0000_0001, 1,  1, 1, 0, 0, 0, 0);
    frame(64'h8000_0000_0000_0001, 1,  0, 0, 0, 0, 0, 0);
    frame(64'h8000_0000_0000_0001, 1,  1, 0, 0, 0, 0, 0);
    frame(64'hF0E1_D2C3_B4A5_9687, 64, 0, 1, 0, 0, 0, 0);
    frame(64'hF0E1_D2C3_B4A5_9687, 64, 1, 0, 0, 0, 0, 0);
    frame(64'h0000_0000_00AB_C123, 24, 0, 1, 0, 0, 0, 1);
    frame(64'hFFFF_FFFF_FFFF_FFFF, 13, 0, 0, 1, 12'hA5C, 12'h3E1, 1);
    frame(64'h0, 24, 1, 0, 1, 12'hFFF, 12'h001, 0);

    for (int i = 0; i < 60; i++)
      frame({$urandom, $urandom}, $urandom_range(1, 64), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 7) == 0), 12'($urandom), 12'($urandom), 1'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule